// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block sits between a DMA-capable device and system memory and turns the device's bus address into a physical address. It fetches one 64-bit translation entry from a flat, single-level table in memory. It accepts one request at a time, made up of an address and a read/write flag. The table base and a control word come in as static configuration. The block then issues exactly one 64-bit read on a simple request/response memory port. It returns the physical address, a page-offset mask and a permission code. Every request walks the table, because no entries are cached.

The control word enables translation, chooses whether the table is indexed in 8 KB or 64 KB steps, and sets a 3-bit size code that widens the address window used as the table index. When translation is off, the address passes straight through with full access. The memory port delivers each entry as one 64-bit word in big-endian order, so bit 63 is the most significant bit of the byte at the lowest address. Each entry has its own valid bit, its own write bit and its own page-size bit. A write that the entry does not allow produces a fault pulse instead of a translation.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, `req_busy`, `rsp_valid`, `rsp_fault` and `mem_rd_valid` are all low.
- R2: While control bit 0 is clear, an accepted request produces `rsp_valid` in the cycle after acceptance, with `rsp_paddr` equal to the request address, `rsp_page_mask` = 0x1fff and `rsp_perm` = 2'b11 (read-write), and no memory read is made.
- R3: With translation on and control bit 2 clear (8 KB layout), `mem_rd_valid` pulses for exactly one cycle, in the cycle after acceptance, with `mem_rd_addr` = base + (address bits [22+code:13] × 8), where code is control bits 18:16.
- R4: With control bit 2 set (64 KB layout) and code 0 to 5, the entry address is base + (address bits [25+code:16] × 8).
- R5: In the 64 KB layout with code 6 or 7, no memory read is issued, and the cycle after acceptance carries a no-permission result (a fault for a write).
- R6: An entry with bit 63 clear yields `rsp_perm` = 2'b00, `rsp_paddr` = 0 and `rsp_page_mask` all ones. The same values are used for every no-permission result.
- R7: For a valid entry, bit 1 set gives `rsp_perm` = 2'b11 and bit 1 clear gives 2'b01 (read-only). The code 2'b10 never appears.
- R8: For a valid entry with bit 61 set, `rsp_paddr` = (entry AND 0x1ffffff8000) OR address[15:0] and the mask is 0xffff. With bit 61 clear, `rsp_paddr` = (entry AND 0x1ffffffe000) OR address[12:0] and the mask is 0x1fff.
- R9: A write request whose permission is not 2'b11 gives a one-cycle `rsp_fault` with `rsp_valid` low. Read requests never fault. `rsp_valid` and `rsp_fault` are never high together.
- R10: `req_busy` is high from the cycle after a table walk is accepted until the result cycle. Requests presented while it is high are ignored, and so is a `mem_rsp_valid` that arrives in the same cycle as the read request.
- R11: The result appears in the cycle after `mem_rsp_valid` is taken, and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Control word: bit 0 enable, bit 2 64 KB layout, bits 18:16 size code |
| cfg_base | input | 64 | Table base address |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Device address to translate |
| req_write | input | 1 | Request is a write access |
| req_busy | output | 1 | Walk in progress; requests not accepted |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry word, big-endian assembled |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_paddr | output | 64 | Physical address |
| rsp_page_mask | output | 64 | Page-offset mask |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Write denied pulse |

## Verification
The bench sweeps both layouts across all eight size codes. Each sweep uses addresses with every index bit set or clear, so an index window that is one bit too wide or too narrow shows up as a wrong `mem_rd_addr`. The two invalid 64 KB codes are checked for a read that must not occur: a walker that fetches anyway would pulse `mem_rd_valid`. Entries of each page size are checked on the offset bit that overlaps the 64 KB physical mask, and a swapped mask changes `rsp_paddr` there. Writes to read-only and invalid entries must fault, and early memory responses and requests made while busy are injected to catch a walker that latches stale data or starts a second walk.

// File: rtl/xw_pkg.sv
// Shared encodings and field positions for the DMA translation walker.
// Assumes 64-bit table entries and 64-bit addresses.
package xw_pkg;
    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b11
    } perm_e;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_LAYOUT_BIT = 2;
    localparam int CTRL_CODE_LSB   = 16;

    localparam int ENT_VALID_BIT   = 63;
    localparam int ENT_BIGPG_BIT   = 61;
    localparam int ENT_WRITE_BIT   = 1;

    localparam int SMALL_SHIFT     = 13;
    localparam int BIG_SHIFT       = 16;
    localparam int ENTRY_LOG2      = 3;
    localparam int BIG_CODE_MAX    = 5;

    localparam logic [63:0] BIG_PHYS_MASK   = 64'h0000_01ff_ffff_8000;
    localparam logic [63:0] SMALL_PHYS_MASK = 64'h0000_01ff_ffff_e000;
    localparam logic [63:0] BIG_OFF_MASK    = 64'h0000_0000_0000_ffff;
    localparam logic [63:0] SMALL_OFF_MASK  = 64'h0000_0000_0000_1fff;
endpackage

// File: rtl/xw_index_calc.sv
// Computes the byte offset of a table entry from the device address.
// The index window is IDX_BASE_W+code bits wide, starting at bit 13
// (8 KB layout) or bit 16 (64 KB layout); each index step is one entry.
// Flags codes that the 64 KB layout does not support.
module xw_index_calc
    import xw_pkg::*;
#(
    parameter int AW         = 64,
    parameter int CODE_W     = 3,
    parameter int IDX_BASE_W = 10
) (
    input  logic [AW-1:0]     va,
    input  logic              big_layout,
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     byte_off,
    output logic              code_ok
);
    localparam int NCODES = 1 << CODE_W;

    logic [AW-1:0] win_mask [NCODES];
    logic [AW-1:0] shifted;

    // One window mask per size code.
    for (genvar c = 0; c < NCODES; c++) begin : g_win
        assign win_mask[c] = (AW'(1) << (IDX_BASE_W + c)) - AW'(1);
    end

    // Select window start, mask the index, scale to entry bytes.
    always_comb begin
        shifted  = big_layout ? (va >> BIG_SHIFT) : (va >> SMALL_SHIFT);
        byte_off = (shifted & win_mask[code]) << ENTRY_LOG2;
        code_ok  = !big_layout || (int'(code) <= BIG_CODE_MAX);
    end
endmodule

// File: rtl/xw_entry_decode.sv
// Decodes one 64-bit translation entry against the original address:
// validity, permission, page size and the physical address.
// A write that is not read-write is flagged as denied.
module xw_entry_decode
    import xw_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [63:0]   entry,
    input  logic [AW-1:0] va,
    input  logic          is_write,
    output logic [AW-1:0] paddr,
    output logic [AW-1:0] pmask,
    output perm_e         perm,
    output logic          deny
);
    // Entry field extraction and address assembly.
    always_comb begin
        if (!entry[ENT_VALID_BIT]) begin
            perm  = PERM_NONE;
            paddr = '0;
            pmask = '1;
        end else begin
            perm = entry[ENT_WRITE_BIT] ? PERM_RW : PERM_RO;
            if (entry[ENT_BIGPG_BIT]) begin
                paddr = AW'(entry & BIG_PHYS_MASK) | (va & AW'(BIG_OFF_MASK));
                pmask = AW'(BIG_OFF_MASK);
            end else begin
                paddr = AW'(entry & SMALL_PHYS_MASK) | (va & AW'(SMALL_OFF_MASK));
                pmask = AW'(SMALL_OFF_MASK);
            end
        end
        deny = is_write && (perm != PERM_RW);
    end
endmodule

// File: rtl/dma_xlate_walker.sv
// DMA address translation walker. Accepts one request at a time, reads a
// single entry from a flat table at cfg_base + offset, and returns a
// one-cycle result or fault pulse. Configuration is sampled on acceptance.
// Assumes the memory answers each read once, no earlier than the cycle
// after mem_rd_valid.
module dma_xlate_walker
    import xw_pkg::*;
#(
    parameter int AW         = 64,
    parameter int CTRL_W     = 32,
    parameter int CODE_W     = 3,
    parameter int IDX_BASE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [AW-1:0]     cfg_base,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    output logic              req_busy,
    output logic              mem_rd_valid,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic [AW-1:0]     rsp_page_mask,
    output logic [1:0]        rsp_perm,
    output logic              rsp_fault
);
    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;

    st_e               state;
    logic [AW-1:0]     va_q;
    logic              wr_q;
    logic [AW-1:0]     ent_addr_q;
    logic              accept;
    logic              xl_en;
    logic              big_layout;
    logic [CODE_W-1:0] size_code;
    logic [AW-1:0]     byte_off;
    logic              code_ok;
    logic [AW-1:0]     dec_paddr;
    logic [AW-1:0]     dec_pmask;
    perm_e             dec_perm;
    logic              dec_deny;
    logic              ctrl_unused;

    // Control field extraction.
    assign xl_en       = cfg_ctrl[CTRL_EN_BIT];
    assign big_layout  = cfg_ctrl[CTRL_LAYOUT_BIT];
    assign size_code   = cfg_ctrl[CTRL_CODE_LSB +: CODE_W];
    assign ctrl_unused = ^cfg_ctrl;

    // Handshake and memory-port outputs.
    assign accept       = req_valid && (state == ST_IDLE);
    assign req_busy     = (state != ST_IDLE);
    assign mem_rd_valid = (state == ST_ISSUE);
    assign mem_rd_addr  = ent_addr_q;

    xw_index_calc #(.AW(AW), .CODE_W(CODE_W), .IDX_BASE_W(IDX_BASE_W)) u_index (
        .va         (req_addr),
        .big_layout (big_layout),
        .code       (size_code),
        .byte_off   (byte_off),
        .code_ok    (code_ok)
    );

    xw_entry_decode #(.AW(AW)) u_decode (
        .entry    (mem_rsp_data),
        .va       (va_q),
        .is_write (wr_q),
        .paddr    (dec_paddr),
        .pmask    (dec_pmask),
        .perm     (dec_perm),
        .deny     (dec_deny)
    );

    // Walk sequencing and registered result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            va_q          <= '0;
            wr_q          <= 1'b0;
            ent_addr_q    <= '0;
            rsp_valid     <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_page_mask <= '0;
            rsp_perm      <= PERM_NONE;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (!xl_en) begin
                            rsp_valid     <= 1'b1;
                            rsp_paddr     <= req_addr;
                            rsp_page_mask <= AW'(SMALL_OFF_MASK);
                            rsp_perm      <= PERM_RW;
                        end else if (!code_ok) begin
                            rsp_valid     <= !req_write;
                            rsp_fault     <= req_write;
                            rsp_paddr     <= '0;
                            rsp_page_mask <= '1;
                            rsp_perm      <= PERM_NONE;
                        end else begin
                            state      <= ST_ISSUE;
                            va_q       <= req_addr;
                            wr_q       <= req_write;
                            ent_addr_q <= cfg_base + byte_off;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        state         <= ST_IDLE;
                        rsp_valid     <= !dec_deny;
                        rsp_fault     <= dec_deny;
                        rsp_paddr     <= dec_paddr;
                        rsp_page_mask <= dec_pmask;
                        rsp_perm      <= dec_perm;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !mem_rd_valid);

    // R10
    read_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> req_busy);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault));

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_busy && !cfg_ctrl[CTRL_EN_BIT])
        |=> (rsp_valid && rsp_paddr == $past(req_addr) && rsp_perm == PERM_RW));

    // R7
    perm_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_perm != 2'b10));

    // R11
    result_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && mem_rsp_valid) |=> (rsp_valid || rsp_fault) && !req_busy);
endmodule

// File: tb/dma_xlate_walker_test.sv
module dma_xlate_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ctrl = '0;
    logic [63:0] cfg_base = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_busy;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic [63:0] rsp_page_mask;
    logic [1:0]  rsp_perm;
    logic        rsp_fault;

    int vectors = 0;
    int errors  = 0;
    logic [63:0] seed = 64'h9e37_79b9_7f4a_7c15;

    always #4 clk = ~clk;

    dma_xlate_walker uut (
        .clk, .rst_n, .cfg_ctrl, .cfg_base, .req_valid, .req_addr, .req_write,
        .req_busy, .mem_rd_valid, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
        .rsp_valid, .rsp_paddr, .rsp_page_mask, .rsp_perm, .rsp_fault
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 7;
        seed ^= seed << 17;
        return seed;
    endfunction

    // One full request: drive, model memory, compare against computed result.
    task automatic run_one(input logic [31:0] ctrl, input logic [63:0] base,
                           input logic [63:0] va, input logic wr,
                           input logic [63:0] ent, input int lat);
        logic        en, big;
        int          code, sh;
        logic [63:0] off, e_pa, e_mask;
        logic [1:0]  e_perm;
        logic        e_fault;
        en   = ctrl[0];
        big  = ctrl[2];
        code = int'(ctrl[18:16]);
        cfg_ctrl = ctrl;
        cfg_base = base;
        @(negedge clk);
        req_valid = 1'b1; req_addr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (!en) begin
            chk("R2 valid", 64'(rsp_valid), 64'd1);
            chk("R2 paddr", rsp_paddr, va);
            chk("R2 mask", rsp_page_mask, 64'h1fff);
            chk("R2 perm", 64'(rsp_perm), 64'd3);
            chk("R2 no read", 64'(mem_rd_valid), 64'd0);
        end else if (big && code > 5) begin
            chk("R5 no read", 64'(mem_rd_valid), 64'd0);
            chk("R5 fault", 64'(rsp_fault), 64'(wr));
            chk("R5 valid", 64'(rsp_valid), 64'(!wr));
            if (!wr) chk("R5 perm", 64'(rsp_perm), 64'd0);
        end else begin
            sh  = big ? 16 : 13;
            off = ((va >> sh) & ((64'd1 << (10 + code)) - 64'd1)) << 3;
            chk("R3 read pulse", 64'(mem_rd_valid), 64'd1);
            chk(big ? "R4 entry addr" : "R3 entry addr", mem_rd_addr, base + off);
            chk("R10 busy", 64'(req_busy), 64'd1);
            // Early response and a request while busy must both be ignored (R10).
            mem_rsp_valid = 1'b1; mem_rsp_data = ~ent;
            req_valid = 1'b1; req_addr = ~va;
            @(negedge clk);
            mem_rsp_valid = 1'b0; req_valid = 1'b0;
            chk("R3 single pulse", 64'(mem_rd_valid), 64'd0);
            chk("R10 no early result", 64'({rsp_valid, rsp_fault}), 64'd0);
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                chk("R10 busy hold", 64'({req_busy, mem_rd_valid}), 64'b10);
            end
            mem_rsp_valid = 1'b1; mem_rsp_data = ent;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (!ent[63]) begin
                e_perm = 2'b00; e_pa = '0; e_mask = '1;
            end else begin
                e_perm = ent[1] ? 2'b11 : 2'b01;
                if (ent[61]) begin
                    e_pa = (ent & 64'h1ffffff8000) | (va & 64'hffff); e_mask = 64'hffff;
                end else begin
                    e_pa = (ent & 64'h1ffffffe000) | (va & 64'h1fff); e_mask = 64'h1fff;
                end
            end
            e_fault = wr && (e_perm != 2'b11);
            chk("R9 fault", 64'(rsp_fault), 64'(e_fault));
            chk("R11 valid", 64'(rsp_valid), 64'(!e_fault));
            chk("R10 busy release", 64'(req_busy), 64'd0);
            if (!e_fault) begin
                chk(ent[63] ? "R7 perm" : "R6 perm", 64'(rsp_perm), 64'(e_perm));
                chk(ent[63] ? "R8 paddr" : "R6 paddr", rsp_paddr, e_pa);
                chk(ent[63] ? "R8 mask" : "R6 mask", rsp_page_mask, e_mask);
            end
        end
        @(negedge clk);
        chk("R11 one-cycle", 64'({rsp_valid, rsp_fault}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 64'({req_busy, rsp_valid, rsp_fault, mem_rd_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 64'({req_busy, rsp_valid, rsp_fault, mem_rd_valid}), 64'd0);
        // Pass-through with several addresses and both access types.
        for (int k = 0; k < 8; k++)
            run_one(32'h0007_0004, 64'h1000, next_rand(), k[0], 64'd0, 0);
        // Sweep layouts, codes, address patterns and entry kinds.
        for (int lay = 0; lay < 2; lay++)
            for (int code = 0; code < 8; code++)
                for (int k = 0; k < 8; k++) begin
                    logic [63:0] va, ent, base;
                    logic [31:0] ctrl;
                    ctrl = 32'(code) << 16 | 32'(lay) << 2 | 32'd1;
                    base = next_rand() & 64'hffff_fff8;
                    va   = (k == 0) ? '1 : (k == 1) ? 64'h0 : next_rand();
                    ent  = next_rand();
                    ent[63] = (k != 2);
                    ent[1]  = k[1];
                    ent[61] = k[2];
                    run_one(ctrl, base, va, k[0] ^ k[2], ent, k % 3);
                end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule